// File: doc/BRIEF.md
# Dual-Domain Micro-Op Dispatcher

This block sits between a micro-op queue and two schedulers, one for integer work and one for floating-point work. Every cycle it looks at the oldest six queue entries. Each entry carries three bits: a valid bit, a domain tag and a fused flag. In a single cycle the block picks the longest run of entries, starting from the oldest, that can legally leave. It then raises one grant bit for each chosen entry, on the grant vector of the scheduler that entry belongs to. It also reports how many entries the queue should pop. Integer and floating-point entries may leave together in the same cycle. Domains do not have to alternate between cycles.

Each scheduler has a credit counter. It starts full after reset. It drops by the credits spent on grants and rises by the credits the scheduler hands back. An entry can only leave when its scheduler holds enough credit for it. A fused entry holds one queue slot but costs two integer credits.

All decisions are combinational and use the credit levels held in registers. The queue pops on the same clock edge at which the counters update.

Top module: `dual_dispatch`

## Requirements
- R1: `deq_count` equals the number of granted entries and never exceeds `TOT_CAP` (default 6).
- R2: Up to `INT_CAP` (default 6) integer entries are granted in one cycle. `int_ops_sent` equals the number of set bits in `int_grant`.
- R3: At most `FP_CAP` (default 4) floating-point entries are granted in one cycle. A fifth floating-point entry is held back.
- R4: An entry with tag bit 0 (integer) can only appear on `int_grant`. An entry with tag bit 1 (floating point) can only appear on `fp_grant`. Both vectors may be non-zero in the same cycle.
- R5: Grants form an unbroken prefix starting at slot 0. The first entry that is blocked, whether by a cap or by a lack of credit, also blocks every younger entry, even if a younger entry could have gone on its own.
- R6: An entry whose valid bit is clear ends the granted run at that slot.
- R7: After reset, the credit levels are `INT_CREDITS` and `FP_CREDITS`. Each clock edge sets the level to the old level, minus the credits spent that cycle, plus the return input. An entry is granted only if its cost fits in the credit that remains. Credits returned in a cycle are usable only from the next cycle.
- R8: A fused integer entry (`q_fused` = 1) takes one slot and counts as one integer op, but costs two integer credits. It is blocked when only one credit remains. The fused flag has no effect on a floating-point entry, which always costs one credit.
- R9: A credit level never exceeds its reset value. Returns that would take it higher are clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | SLOTS | Valid bit of each queue-head slot, with slot 0 the oldest |
| q_is_fp | input | SLOTS | Domain tag: 0 for integer, 1 for floating point |
| q_fused | input | SLOTS | Fused flag (costs two integer credits) |
| int_credit_ret | input | ICW | Integer credits returned this cycle |
| fp_credit_ret | input | FCW | Floating-point credits returned this cycle |
| deq_count | output | CW | Number of entries to pop from the queue head |
| int_grant | output | SLOTS | Slots sent to the integer scheduler |
| fp_grant | output | SLOTS | Slots sent to the floating-point scheduler |
| int_ops_sent | output | CW | Number of integer entries granted |
| fp_ops_sent | output | CW | Number of floating-point entries granted |
| int_credits | output | ICW | Current integer credit level |
| fp_credits | output | FCW | Current floating-point credit level |

## Verification
The only state in this block is the two credit levels, so any error in credit accounting shows up as a wrong level on the very next cycle. It then turns into wrong grants once the stream of ops draws the level near zero. The tests drive counters down to exactly zero, to one credit, and to partial refills. At those points a spent count that is off by one, or a missing clamp, changes `deq_count` immediately. Errors in the selection chain, such as a cap compared against the wrong count or a gap that is skipped instead of stopping the run, appear in the same cycle on the grant vectors.

// File: rtl/disp_pkg.sv
package disp_pkg;

   // Domain tag carried with each queue-head entry.
   typedef enum logic {
      DOM_INT = 1'b0,
      DOM_FP  = 1'b1
   } dom_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int bits_for(input int value);
      return (value < 1) ? 1 : $clog2(value + 1);
   endfunction

endpackage

// File: rtl/disp_credit.sv
// Credit counter for one scheduler: spend on grants, refill on return, clamp at full.
module disp_credit #(
   parameter  int MAX = 16,
   localparam int W   = disp_pkg::bits_for(MAX)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] spend,
   input  logic [W-1:0] refill,
   output logic [W-1:0] level
);
   localparam int W1 = W + 1;
   localparam logic [W1-1:0] FULL = W1'(MAX);

   logic [W1-1:0] raw;
   logic [W1-1:0] nxt;

   always_comb begin
      raw = {1'b0, level} + {1'b0, refill} - {1'b0, spend};
      nxt = (raw > FULL) ? FULL : raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) level <= W'(MAX);
      else        level <= nxt[W-1:0];
   end
endmodule

// File: rtl/disp_select.sv
// In-order selection chain: walks slots oldest first, stops at the first blocked entry.
module disp_select #(
   parameter int SLOTS    = 6,
   parameter int TOT_CAP  = 6,
   parameter int INT_CAP  = 6,
   parameter int FP_CAP   = 4,
   parameter bit FUSED_EN = 1'b1,
   parameter int ICW      = 5,
   parameter int FCW      = 4,
   parameter int CW       = 3
) (
   input  logic [SLOTS-1:0] valid,
   input  logic [SLOTS-1:0] is_fp,
   input  logic [SLOTS-1:0] fused,
   input  logic [ICW-1:0]   int_avail,
   input  logic [FCW-1:0]   fp_avail,
   output logic [SLOTS-1:0] grant_int,
   output logic [SLOTS-1:0] grant_fp,
   output logic [CW-1:0]    n_total,
   output logic [CW-1:0]    n_int,
   output logic [CW-1:0]    n_fp,
   output logic [ICW-1:0]   int_spent,
   output logic [FCW-1:0]   fp_spent
);
   import disp_pkg::*;

   localparam int AW = max_of(max_of(ICW, FCW), CW) + 2;
   localparam logic [AW-1:0] ONE   = AW'(1);
   localparam logic [AW-1:0] TWO   = AW'(2);
   localparam logic [AW-1:0] TOT_L = AW'(TOT_CAP);
   localparam logic [AW-1:0] INT_L = AW'(INT_CAP);
   localparam logic [AW-1:0] FP_L  = AW'(FP_CAP);

   // Variant choice: with fusion disabled every integer entry costs one credit.
   logic [SLOTS-1:0] fused_eff;
   generate
      if (FUSED_EN) begin : g_fuse
         assign fused_eff = fused;
      end else begin : g_nofuse
         logic unused_fused;
         assign unused_fused = ^fused;
         assign fused_eff    = '0;
      end
   endgenerate

   logic [AW-1:0] tot, ni, nf, ci, cf, cost;
   logic [AW-1:0] int_have, fp_have;
   logic          go;

   assign int_have = AW'(int_avail);
   assign fp_have  = AW'(fp_avail);

   always_comb begin
      grant_int = '0;
      grant_fp  = '0;
      tot  = '0;
      ni   = '0;
      nf   = '0;
      ci   = '0;
      cf   = '0;
      cost = ONE;
      go   = 1'b1;
      for (int i = 0; i < SLOTS; i++) begin
         cost = fused_eff[i] ? TWO : ONE;
         if (!go || !valid[i]) begin
            go = 1'b0;
         end else if (dom_e'(is_fp[i]) == DOM_FP) begin
            if (tot < TOT_L && nf < FP_L && (cf + ONE) <= fp_have) begin
               grant_fp[i] = 1'b1;
               tot = tot + ONE;
               nf  = nf + ONE;
               cf  = cf + ONE;
            end else begin
               go = 1'b0;
            end
         end else begin
            if (tot < TOT_L && ni < INT_L && (ci + cost) <= int_have) begin
               grant_int[i] = 1'b1;
               tot = tot + ONE;
               ni  = ni + ONE;
               ci  = ci + cost;
            end else begin
               go = 1'b0;
            end
         end
      end
      n_total   = tot[CW-1:0];
      n_int     = ni[CW-1:0];
      n_fp      = nf[CW-1:0];
      int_spent = ci[ICW-1:0];
      fp_spent  = cf[FCW-1:0];
   end
endmodule

// File: rtl/dual_dispatch.sv
// Top: steers up to SLOTS queue-head entries to integer and floating-point schedulers per cycle.
module dual_dispatch #(
   parameter  int SLOTS       = 6,
   parameter  int TOT_CAP     = 6,
   parameter  int INT_CAP     = 6,
   parameter  int FP_CAP      = 4,
   parameter  int INT_CREDITS = 16,
   parameter  int FP_CREDITS  = 8,
   parameter  bit FUSED_EN    = 1'b1,
   localparam int ICW         = disp_pkg::bits_for(INT_CREDITS),
   localparam int FCW         = disp_pkg::bits_for(FP_CREDITS),
   localparam int CW          = disp_pkg::bits_for(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] q_valid,
   input  logic [SLOTS-1:0] q_is_fp,
   input  logic [SLOTS-1:0] q_fused,
   input  logic [ICW-1:0]   int_credit_ret,
   input  logic [FCW-1:0]   fp_credit_ret,
   output logic [CW-1:0]    deq_count,
   output logic [SLOTS-1:0] int_grant,
   output logic [SLOTS-1:0] fp_grant,
   output logic [CW-1:0]    int_ops_sent,
   output logic [CW-1:0]    fp_ops_sent,
   output logic [ICW-1:0]   int_credits,
   output logic [FCW-1:0]   fp_credits
);
   // Elaboration-time parameter checks.
   generate
      if (SLOTS < 1 || TOT_CAP < 1 || TOT_CAP > SLOTS) begin : g_bad_total
         $error("dual_dispatch: TOT_CAP must lie in 1..SLOTS");
      end
      if (INT_CAP < 1 || INT_CAP > TOT_CAP || FP_CAP < 1 || FP_CAP > TOT_CAP) begin : g_bad_caps
         $error("dual_dispatch: domain caps must lie in 1..TOT_CAP");
      end
      if (INT_CREDITS < (FUSED_EN ? 2 : 1) || FP_CREDITS < 1) begin : g_bad_credits
         $error("dual_dispatch: credit pools too small to issue any entry");
      end
   endgenerate

   logic [ICW-1:0] int_spent;
   logic [FCW-1:0] fp_spent;

   disp_select #(
      .SLOTS    (SLOTS),
      .TOT_CAP  (TOT_CAP),
      .INT_CAP  (INT_CAP),
      .FP_CAP   (FP_CAP),
      .FUSED_EN (FUSED_EN),
      .ICW      (ICW),
      .FCW      (FCW),
      .CW       (CW)
   ) u_select (
      .valid     (q_valid),
      .is_fp     (q_is_fp),
      .fused     (q_fused),
      .int_avail (int_credits),
      .fp_avail  (fp_credits),
      .grant_int (int_grant),
      .grant_fp  (fp_grant),
      .n_total   (deq_count),
      .n_int     (int_ops_sent),
      .n_fp      (fp_ops_sent),
      .int_spent (int_spent),
      .fp_spent  (fp_spent)
   );

   disp_credit #(.MAX(INT_CREDITS)) u_int_credit (
      .clk    (clk),
      .rst_n  (rst_n),
      .spend  (int_spent),
      .refill (int_credit_ret),
      .level  (int_credits)
   );

   disp_credit #(.MAX(FP_CREDITS)) u_fp_credit (
      .clk    (clk),
      .rst_n  (rst_n),
      .spend  (fp_spent),
      .refill (fp_credit_ret),
      .level  (fp_credits)
   );
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
   parameter int SLOTS       = 6,
   parameter int TOT_CAP     = 6,
   parameter int INT_CAP     = 6,
   parameter int FP_CAP      = 4,
   parameter int INT_CREDITS = 16,
   parameter int FP_CREDITS  = 8,
   parameter bit FUSED_EN    = 1'b1,
   parameter int ICW         = 5,
   parameter int FCW         = 4,
   parameter int CW          = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SLOTS-1:0] q_valid,
   input logic [SLOTS-1:0] q_is_fp,
   input logic [SLOTS-1:0] q_fused,
   input logic [ICW-1:0]   int_credit_ret,
   input logic [FCW-1:0]   fp_credit_ret,
   input logic [CW-1:0]    deq_count,
   input logic [SLOTS-1:0] int_grant,
   input logic [SLOTS-1:0] fp_grant,
   input logic [CW-1:0]    int_ops_sent,
   input logic [CW-1:0]    fp_ops_sent,
   input logic [ICW-1:0]   int_credits,
   input logic [FCW-1:0]   fp_credits
);
   logic [SLOTS-1:0] all_g;
   logic [SLOTS:0]   g_inc;
   int int_cost, fp_cost, exp_int, exp_fp;

   assign all_g = int_grant | fp_grant;
   assign g_inc = {1'b0, all_g} + 1'b1;

   always_comb begin
      int_cost = $countones(int_grant) + (FUSED_EN ? $countones(int_grant & q_fused) : 0);
      fp_cost  = $countones(fp_grant);
      exp_int  = int'(int_credits) + int'(int_credit_ret) - int_cost;
      if (exp_int > INT_CREDITS) exp_int = INT_CREDITS;
      exp_fp   = int'(fp_credits) + int'(fp_credit_ret) - fp_cost;
      if (exp_fp > FP_CREDITS) exp_fp = FP_CREDITS;
   end

   p_total_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(deq_count) <= TOT_CAP && int'(deq_count) == $countones(all_g));

   p_int_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(int_grant) <= INT_CAP && int'(int_ops_sent) == $countones(int_grant));

   p_fp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fp_grant) <= FP_CAP && int'(fp_ops_sent) == $countones(fp_grant));

   p_domain_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_grant & ~q_is_fp) == '0 && (int_grant & q_is_fp) == '0);

   p_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (g_inc[SLOTS-1:0] & all_g) == '0);

   p_valid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (all_g & ~q_valid) == '0);

   p_int_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(int_credits) == $past(exp_int));

   p_fp_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(fp_credits) == $past(exp_fp));

   p_no_overdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int_cost <= int'(int_credits) && fp_cost <= int'(fp_credits));

   p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(int_credits) <= INT_CREDITS && int'(fp_credits) <= FP_CREDITS);
endmodule

bind dual_dispatch disp_checker #(
   .SLOTS       (SLOTS),
   .TOT_CAP     (TOT_CAP),
   .INT_CAP     (INT_CAP),
   .FP_CAP      (FP_CAP),
   .INT_CREDITS (INT_CREDITS),
   .FP_CREDITS  (FP_CREDITS),
   .FUSED_EN    (FUSED_EN),
   .ICW         (ICW),
   .FCW         (FCW),
   .CW          (CW)
) u_disp_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .q_valid        (q_valid),
   .q_is_fp        (q_is_fp),
   .q_fused        (q_fused),
   .int_credit_ret (int_credit_ret),
   .fp_credit_ret  (fp_credit_ret),
   .deq_count      (deq_count),
   .int_grant      (int_grant),
   .fp_grant       (fp_grant),
   .int_ops_sent   (int_ops_sent),
   .fp_ops_sent    (fp_ops_sent),
   .int_credits    (int_credits),
   .fp_credits     (fp_credits)
);

// File: tb/dual_dispatch_test.sv
module dual_dispatch_test;
   localparam int S = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [S-1:0] q_valid = '0, q_is_fp = '0, q_fused = '0;
   logic [4:0]   int_credit_ret = '0;
   logic [3:0]   fp_credit_ret = '0;
   logic [2:0]   deq_count, int_ops_sent, fp_ops_sent;
   logic [S-1:0] int_grant, fp_grant;
   logic [4:0]   int_credits;
   logic [3:0]   fp_credits;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   dual_dispatch uut (
      .clk(clk), .rst_n(rst_n),
      .q_valid(q_valid), .q_is_fp(q_is_fp), .q_fused(q_fused),
      .int_credit_ret(int_credit_ret), .fp_credit_ret(fp_credit_ret),
      .deq_count(deq_count), .int_grant(int_grant), .fp_grant(fp_grant),
      .int_ops_sent(int_ops_sent), .fp_ops_sent(fp_ops_sent),
      .int_credits(int_credits), .fp_credits(fp_credits)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One cycle of stimulus: drive at the falling edge, settle, let the caller sample.
   task automatic step(input logic [S-1:0] v, input logic [S-1:0] f, input logic [S-1:0] fu,
                       input int ir, input int fr);
      @(negedge clk);
      q_valid = v; q_is_fp = f; q_fused = fu;
      int_credit_ret = 5'(ir); fp_credit_ret = 4'(fr);
      #1;
   endtask

   task automatic levels(input string tag, input int ei, input int ef);
      chk({tag, " int level"}, int'(int_credits), ei);
      chk({tag, " fp level"}, int'(fp_credits), ef);
   endtask

   task automatic t_reset;
      step('0, '0, '0, 0, 0);
      levels("R7 reset", 16, 8);
      chk("R6 nothing valid", int'(deq_count), 0);
   endtask

   task automatic t_int_six;
      step(6'h3F, '0, '0, 0, 0);
      chk("R1 six int deq", int'(deq_count), 6);
      chk("R2 six int grant", int'(int_grant), 6'h3F);
      chk("R2 int ops", int'(int_ops_sent), 6);
      step('0, '0, '0, 6, 0);
      levels("R7 after six int", 10, 8);
      step('0, '0, '0, 0, 0);
      levels("R7 refilled", 16, 8);
   endtask

   task automatic t_mixed;
      step(6'h3F, 6'b001010, '0, 0, 0);
      chk("R4 mixed deq", int'(deq_count), 6);
      chk("R4 mixed int grant", int'(int_grant), 6'b110101);
      chk("R4 mixed fp grant", int'(fp_grant), 6'b001010);
      chk("R4 mixed fp ops", int'(fp_ops_sent), 2);
      step('0, '0, '0, 4, 2);
      levels("R7 after mixed", 12, 6);
      step('0, '0, '0, 0, 0);
   endtask

   task automatic t_fp_cap;
      step(6'h3F, 6'h3F, '0, 0, 0);
      chk("R3 fp cap deq", int'(deq_count), 4);
      chk("R3 fp cap grant", int'(fp_grant), 6'b001111);
      step('0, '0, '0, 0, 4);
      levels("R3 fp spent", 16, 4);
      step(6'h3F, 6'b011111, '0, 0, 0);
      chk("R5 int behind blocked fp deq", int'(deq_count), 4);
      chk("R5 int behind blocked fp grant", int'(int_grant), 0);
      step('0, '0, '0, 0, 4);
      step(6'b111011, '0, '0, 0, 0);
      levels("R7 fp refilled", 16, 8);
      chk("R6 gap stops run", int'(deq_count), 2);
      chk("R6 gap grant", int'(int_grant), 6'b000011);
      step('0, '0, '0, 2, 0);
   endtask

   task automatic t_fused;
      step(6'h3F, '0, 6'b000011, 0, 0);
      levels("R8 start", 16, 8);
      chk("R8 two fused deq", int'(deq_count), 6);
      chk("R8 fused op count", int'(int_ops_sent), 6);
      step(6'h3F, '0, 6'h3F, 0, 0);
      chk("R8 fused level", int'(int_credits), 8);
      chk("R8 all fused deq", int'(deq_count), 4);
      step(6'h3F, '0, '0, 0, 0);
      chk("R7 empty level", int'(int_credits), 0);
      chk("R7 no credit stall", int'(deq_count), 0);
      step(6'h3F, '0, '0, 3, 0);
      chk("R7 return not usable same cycle", int'(deq_count), 0);
      step(6'h3F, '0, 6'b000001, 0, 0);
      chk("R7 three credits", int'(int_credits), 3);
      chk("R8 partial fused deq", int'(deq_count), 2);
      step('0, '0, '0, 1, 0);
      chk("R7 drained", int'(int_credits), 0);
      step(6'h3F, '0, 6'b000001, 0, 0);
      chk("R8 one credit level", int'(int_credits), 1);
      chk("R8 fused needs two", int'(deq_count), 0);
      step('0, '0, '0, 15, 0);
      step('0, '0, '0, 0, 0);
      levels("R7 fused refilled", 16, 8);
   endtask

   task automatic t_fp_fused;
      step(6'b000001, 6'b000001, 6'b000001, 0, 0);
      chk("R8 fp fused deq", int'(deq_count), 1);
      step('0, '0, '0, 0, 1);
      levels("R8 fp fused one credit", 16, 7);
      step('0, '0, '0, 0, 0);
   endtask

   task automatic t_fp_stall;
      step(6'h3F, 6'h3F, '0, 0, 0);
      step(6'h3F, 6'h3F, '0, 0, 0);
      chk("R3 second fp burst", int'(deq_count), 4);
      step(6'b000011, 6'b000001, '0, 0, 0);
      chk("R7 fp level zero", int'(fp_credits), 0);
      chk("R5 fp stall blocks int", int'(deq_count), 0);
      step(6'b000011, 6'b000010, '0, 0, 0);
      chk("R5 int ahead of stalled fp", int'(int_grant), 6'b000001);
      step('0, '0, '0, 1, 8);
      levels("R7 after fp stall", 15, 0);
      step('0, '0, '0, 0, 0);
      levels("R7 fp stall refilled", 16, 8);
   endtask

   task automatic t_clamp;
      step('0, '0, '0, 5, 3);
      step(6'h3F, '0, '0, 6, 0);
      levels("R9 clamp", 16, 8);
      chk("R9 full send", int'(deq_count), 6);
      step('0, '0, '0, 0, 0);
      levels("R9 send with return", 16, 8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_int_six();
      t_mixed();
      t_fp_cap();
      t_fused();
      t_fp_fused();
      t_fp_stall();
      t_clamp();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule